// File: doc/BRIEF.md
# Fault-Tolerant Pulse Synchronizer Node

This block is the per-node controller of a pulse synchronization scheme. It serves a fully connected group of N nodes, and up to F of those nodes may behave arbitrarily. The node keeps one sticky vote flag for every sender, its own slot included. Each flag records that the sender announced a propose transition during the current round. A five-state machine (RESET, START, PROPOSE, PULSE, READY) moves on local cycle timeouts and on the number of flags that are set. The node emits a one-cycle broadcast strobe when it enters PROPOSE and a one-cycle pulse when it enters PULSE.

The system wires every node's broadcast strobe, through its message network, to the matching bit of every node's vote input, the node's own bit included. Two vote thresholds drive the machine. More than F votes pull a lagging node into PROPOSE. N−F votes fire the pulse. The votes are forgotten only when the node leaves RESET and when it leaves PULSE. All timeouts and the start time are counted in local clock cycles. A configuration with 3F ≥ N is rejected at elaboration.

Top module: `pulse_sync_node`

## Requirements
- R1: A synchronous active-high reset puts the node in RESET, clears every vote flag and holds both output strobes low.
- R2: After reset is released the node stays in RESET for exactly H0 cycles and then enters START. With no votes it enters PROPOSE T1 cycles later, so the first broadcast strobe appears H0+T1 cycles after release.
- R3: In START, a vote count of F+1 or more moves the node to PROPOSE on the next clock edge, ahead of the T1 timeout. A count of F does not move it.
- R4: In PROPOSE the node enters PULSE on the clock edge after the vote count reaches N−F. A count of N−F−1 leaves it waiting, and PULSE is entered only from PROPOSE.
- R5: The node stays in PULSE for exactly T2 cycles and then enters READY.
- R6: With no votes, the node leaves READY for PROPOSE after exactly T3 cycles.
- R7: In READY, a vote count of F+1 or more moves the node to PROPOSE on the next clock edge. A count of F does not move it.
- R8: All vote flags are cleared on the RESET→START and PULSE→READY transitions, and at no other time. A strobe on propose_in[i] that arrives in the same cycle as a clear is discarded.
- R9: propose_out and pulse_out are registered. Each is high for exactly one cycle, the first cycle of PROPOSE or of PULSE respectively, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local node clock |
| rst | input | 1 | Synchronous active-high reset |
| propose_in | input | N | One single-cycle vote strobe per sender; bit i sets flag i |
| propose_out | output | 1 | One-cycle broadcast strobe on entry into PROPOSE |
| pulse_out | output | 1 | One-cycle pulse on entry into PULSE |

## Verification
The node runs in a four-node, one-fault configuration with short timeouts, and every cycle of several rounds is compared against event times worked out from H0, T1, T2 and T3. A timeout-only round fixes the baseline timing. Votes are then added one at a time, which separates the F and F+1 pull-in boundary from the N−F−1 and N−F pulse boundary. Strobes are also sent in RESET, during PULSE and in the cycle of the clear. A flag that was not cleared would then produce an early broadcast, so these patterns tell correct clearing apart from leftover votes. A reset in mid-round shows that the node restarts its timing from RESET.

// File: rtl/psn_pkg.sv
package psn_pkg;
  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_START   = 3'd1,
    ST_PROPOSE = 3'd2,
    ST_PULSE   = 3'd3,
    ST_READY   = 3'd4
  } psn_state_e;
endpackage

// File: rtl/psn_flags.sv
module psn_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] set_in,
  output logic [N-1:0] flags_q
);
  // clear has priority over a strobe in the same cycle
  always_ff @(posedge clk) begin
    if (rst || clr) flags_q <= '0;
    else            flags_q <= flags_q | set_in;
  end
endmodule

// File: rtl/psn_vote.sv
module psn_vote #(
  parameter int N = 4,
  parameter int F = 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0] flags,
  output logic         pull_in,
  output logic         quorum
);
  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + CW'(flags[i]);
  end

  assign pull_in = (cnt >= CW'(F + 1));
  assign quorum  = (cnt >= CW'(N - F));
endmodule

// File: rtl/psn_timer.sv
module psn_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (rst || restart)     count_q <= '0;
    else if (count_q != '1) count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/pulse_sync_node.sv
module pulse_sync_node
  import psn_pkg::*;
#(
  parameter int N  = 4,
  parameter int F  = 1,
  parameter int H0 = 16,
  parameter int T1 = 32,
  parameter int T2 = 12,
  parameter int T3 = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] propose_in,
  output logic         propose_out,
  output logic         pulse_out
);
  localparam int MAXA = (H0 > T1) ? H0 : T1;
  localparam int MAXB = (T2 > T3) ? T2 : T3;
  localparam int MAXT = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int TW   = $clog2(MAXT + 1);

  if (3 * F >= N) begin : g_bad_cfg
    $fatal(1, "pulse_sync_node: fault bound requires 3*F < N");
  end

  psn_state_e    state_q, nxt;
  logic [N-1:0]  flags_q;
  logic [TW-1:0] timer_q;
  logic          pull_in, quorum, clr, restart;

  psn_flags #(.N(N)) u_flags (
    .clk(clk), .rst(rst), .clr(clr), .set_in(propose_in), .flags_q(flags_q)
  );

  psn_vote #(.N(N), .F(F)) u_vote (
    .flags(flags_q), .pull_in(pull_in), .quorum(quorum)
  );

  psn_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .restart(restart), .count_q(timer_q)
  );

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_RESET:   if (timer_q == TW'(H0 - 1))            nxt = ST_START;
      ST_START:   if (pull_in || timer_q == TW'(T1 - 1)) nxt = ST_PROPOSE;
      ST_PROPOSE: if (quorum)                            nxt = ST_PULSE;
      ST_PULSE:   if (timer_q == TW'(T2 - 1))            nxt = ST_READY;
      ST_READY:   if (pull_in || timer_q == TW'(T3 - 1)) nxt = ST_PROPOSE;
      default:                                           nxt = ST_RESET;
    endcase
  end

  assign restart = (nxt != state_q);
  assign clr     = (state_q == ST_RESET && nxt == ST_START) ||
                   (state_q == ST_PULSE && nxt == ST_READY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_RESET;
      propose_out <= 1'b0;
      pulse_out   <= 1'b0;
    end else begin
      state_q     <= nxt;
      propose_out <= (nxt == ST_PROPOSE) && (state_q != ST_PROPOSE);
      pulse_out   <= (nxt == ST_PULSE) && (state_q != ST_PULSE);
    end
  end
endmodule

// File: rtl/psn_node_chk.sv
module psn_node_chk
  import psn_pkg::*;
#(
  parameter int N  = 4,
  parameter int TW = 8,
  parameter int H0 = 16
) (
  input logic          clk,
  input logic          rst,
  input psn_state_e    state_q,
  input logic [N-1:0]  flags_q,
  input logic [TW-1:0] timer_q,
  input logic          propose_out,
  input logic          pulse_out
);
  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_out |=> !pulse_out);
  // R9
  bcast_single_chk: assert property (@(posedge clk) disable iff (rst)
    propose_out |=> !propose_out);
  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(pulse_out && propose_out));
  // R4
  pulse_from_propose_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_out |-> ($past(state_q) == ST_PROPOSE));
  // R8
  ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READY && $past(state_q) == ST_PULSE) |-> (flags_q == '0));
  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START && $past(state_q) == ST_RESET) |-> (flags_q == '0));
  // R8
  flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == $past(state_q)) |-> ((flags_q & $past(flags_q)) == $past(flags_q)));
  // R2
  reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START && $past(state_q) == ST_RESET) |-> ($past(timer_q) == TW'(H0 - 1)));
endmodule

bind pulse_sync_node psn_node_chk #(.N(N), .TW(TW), .H0(H0)) u_chk (
  .clk(clk), .rst(rst), .state_q(state_q), .flags_q(flags_q),
  .timer_q(timer_q), .propose_out(propose_out), .pulse_out(pulse_out)
);

// File: tb/pulse_sync_node_bench.sv
module pulse_sync_node_bench;
  localparam int N = 4, F = 1, H0 = 5, T1 = 6, T2 = 4, T3 = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] propose_in = '0;
  logic propose_out, pulse_out;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pulse_sync_node #(.N(N), .F(F), .H0(H0), .T1(T1), .T2(T2), .T3(T3)) u_pulse_sync_node (
    .clk(clk), .rst(rst), .propose_in(propose_in),
    .propose_out(propose_out), .pulse_out(pulse_out)
  );

  task automatic chk(input string req, input string what, input int k,
                     input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s step %0d: actual %b expected %b", req, what, k, act, exp);
    end
  endtask

  // inputs change at the falling edge; outputs are sampled at the next falling edge
  task automatic step(input logic [N-1:0] v, input logic r);
    propose_in = v;
    rst        = r;
    @(negedge clk);
  endtask

  initial begin
    logic [N-1:0] v;
    string req;
    @(negedge clk);
    // R1: reset state
    for (int k = 0; k < 3; k++) begin
      step('0, 1'b1);
      chk("R1", "propose_out", k, propose_out, 1'b0);
      chk("R1", "pulse_out", k, pulse_out, 1'b0);
    end

    // Round A: timeout path, pulse threshold, PULSE hold, clear, READY pull-in
    for (int k = 1; k <= 42; k++) begin
      case (k)
        13: v = 4'b0011;  // two votes: below N-F
        14: v = 4'b0100;  // third vote: quorum
        16: v = 4'b1000;  // vote during PULSE, must be forgotten
        19: v = 4'b0011;  // strobes in the clear cycle, discarded
        28: v = 4'b0111;  // quorum at once in PROPOSE
        34: v = 4'b0001;  // single vote in READY: not enough
        35: v = 4'b0010;  // second vote: pull-in
        38: v = 4'b0100;  // quorum
        default: v = '0;
      endcase
      case (k)
        11:             req = "R2";
        12:             req = "R9";
        14, 15, 29, 39: req = "R4";
        16, 17, 18:     req = "R5";
        20, 21, 22:     req = "R8";
        27:             req = "R5 R6";
        35, 36:         req = "R7";
        default:        req = "R9";
      endcase
      step(v, 1'b0);
      chk(req, "propose_out", k, propose_out, (k == 11) || (k == 27) || (k == 36));
      chk(req, "pulse_out", k, pulse_out, (k == 15) || (k == 29) || (k == 39));
    end

    // R1: reset in mid-round
    for (int k = 0; k < 2; k++) begin
      step(4'b1111, 1'b1);
      chk("R1", "propose_out", k, propose_out, 1'b0);
      chk("R1", "pulse_out", k, pulse_out, 1'b0);
    end

    // Round B: votes in RESET must be cleared, START pull-in
    for (int k = 1; k <= 14; k++) begin
      case (k)
        2:       v = 4'b0111;
        7:       v = 4'b0011;
        9:       v = 4'b0100;
        default: v = '0;
      endcase
      case (k)
        6:       req = "R8";
        7, 8:    req = "R3";
        10:      req = "R4";
        default: req = "R2";
      endcase
      step(v, 1'b0);
      chk(req, "propose_out", k, propose_out, (k == 8));
      chk(req, "pulse_out", k, pulse_out, (k == 10));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule